// File: doc/BRIEF.md
# Multi-PHY Cell and Packet-Chunk Port

This block is the PHY side of a UTOPIA Level 2 style multi-PHY bus with a 16-bit data path, in the receive direction. It serves four channels, and each channel has its own 5-bit bus address. A bus master polls by placing an address on the bus. One cycle later, the block reports whether the addressed channel has a unit ready to send. The master then selects that channel and enables the transfer. The whole unit then moves word by word with no further handshake.

In ATM mode a unit is one cell of 27 words: 53 bytes plus a pad byte. In packet mode a unit is a fixed-size chunk of 16, 32, 48 or 64 bytes. A chunk may end early on the word that carries the end-of-packet marker. Sideband outputs travel with the data words:
- start of unit
- start of packet
- end of packet
- a single-byte flag for the final word
- abort
- FCS error

The framing logic behind each channel presents its head word, along with that word's flags and a ready flag. It guarantees that once it is ready, it can supply a whole unit on consecutive cycles. The block pops one word per transferred cycle.

Top module: `mphy_chunk_port`

## Requirements
- R1: In the cycle after an address is sampled, `rx_clav_oe` is 1 exactly when the address equals some channel's configured address. `rx_clav` then equals that channel's `ch_ready`. When no channel matches, both outputs are 0.
- R2: When several channels share an address, the lowest-numbered channel answers the poll and is the one selected.
- R3: A channel is selected on a clock edge where `rx_enb_n` is 1 and the address matches, unless a unit is moving at that edge. A selection arriving during a unit is ignored. The unit starts on the first later edge where `rx_enb_n` is 0 and the selected channel's `ch_ready` is 1. The first word appears on `rx_data` in the following cycle, with `rx_val` = 1 and `rx_soc` = 1.
- R4: With `cfg_ppp_mode` = 0, a unit is exactly 27 consecutive words, whatever `rx_enb_n` does while the unit is moving. In this mode `rx_sop`, `rx_eop`, `rx_mod`, `rx_abort` and `rx_fcserr` stay 0 even if the channel flags are set.
- R5: With `cfg_ppp_mode` = 1, `cfg_chunk_code` values 0, 1, 2 and 3 give chunks of 16, 32, 48 and 64 bytes. These are 8, 16, 24 and 32 consecutive words.
- R6: In packet mode, a chunk ends on the word whose channel end flag is set, even if the chunk is not full. That word carries `rx_eop` = 1. It also carries `rx_mod` = 1 when only bits 15:8 are valid. `rx_sop` follows the channel's start flag.
- R7: In packet mode, `rx_abort` and `rx_fcserr` follow the channel's flags only on the end-of-packet word. On every other word they are 0.
- R8: When a unit ends, the selection is cleared. Holding `rx_enb_n` at 0 afterwards moves nothing until a channel is selected again.
- R9: `ch_pop` marks only the selected channel, once per moved word. The words appear on `rx_data` unchanged and in channel order, one cycle after the pop.
- R10: While `rst_n` is 0, all outputs are 0 from the next edge onwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ppp_mode | input | 1 | 0 = ATM cells, 1 = packet chunks |
| cfg_chunk_code | input | 2 | Chunk size code: 0..3 gives 16/32/48/64 bytes |
| cfg_ch_addr | input | 20 | Channel bus addresses, 5 bits each; channel 0 in the low bits |
| rx_addr | input | 5 | Polling and selection address from the master |
| rx_enb_n | input | 1 | Active-low enable from the master |
| rx_clav | output | 1 | Unit available for the address polled last cycle |
| rx_clav_oe | output | 1 | Drive enable for `rx_clav` (address matched) |
| rx_data | output | 16 | Data word |
| rx_val | output | 1 | `rx_data` carries a word |
| rx_soc | output | 1 | First word of a cell or chunk |
| rx_sop | output | 1 | Start of packet (packet mode) |
| rx_eop | output | 1 | End of packet (packet mode) |
| rx_mod | output | 1 | End word holds only bits 15:8 |
| rx_abort | output | 1 | Packet aborted (on end word) |
| rx_fcserr | output | 1 | Packet FCS error (on end word) |
| ch_ready | input | 4 | Channel has a complete unit ready |
| ch_word | input | 64 | Head word for each channel, 16 bits each |
| ch_sop | input | 4 | Head word starts a packet |
| ch_eop | input | 4 | Head word ends a packet |
| ch_mod | input | 4 | Head end word holds one byte |
| ch_abort | input | 4 | Head end word marks an abort |
| ch_fcserr | input | 4 | Head end word marks an FCS error |
| ch_pop | output | 4 | Head word consumed this cycle |

## Verification
The bench uses the default parameters: four channels, 5-bit addresses, a 16-bit bus, a 27-word cell and a 16-byte chunk step. Four channels are enough to give two of them the same address, which exposes the priority rule. The 16-byte step puts all four chunk codes (8 to 32 words) within a short run. With these values, a full 27-word cell, an early end-of-packet inside a chunk, and a selection made during a moving unit are all reached within a few hundred cycles.

// File: rtl/mphy_pkg.sv
// Shared types and helpers for the multi-PHY cell/chunk port.
// Assumes the chunk step in bytes is a multiple of the bus width in bytes.
package mphy_pkg;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_ARMED = 2'd1,
        PS_MOVE  = 2'd2
    } port_state_t;

    // Words in a chunk for a size code: (code + 1) steps of step_bytes.
    function automatic int unsigned chunk_words(input logic [1:0] code,
                                                input int unsigned step_bytes,
                                                input int unsigned bus_bytes);
        return ((int'(code) + 1) * step_bytes) / bus_bytes;
    endfunction

endpackage

// File: rtl/mphy_addr_match.sv
// Compares the bus address against every channel's configured address.
// Reports a hit and the lowest-numbered matching channel.
// Assumes NCH >= 1; purely combinational.
module mphy_addr_match #(
    parameter int NCH = 4,
    parameter int AW  = 5,
    parameter int IW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [AW-1:0]     addr,
    input  logic [NCH*AW-1:0] cfg_addr,
    output logic              hit,
    output logic [IW-1:0]     idx
);

    logic [NCH-1:0] eq;

    for (genvar g = 0; g < NCH; g++) begin : g_cmp
        assign eq[g] = (addr == cfg_addr[g*AW +: AW]);
    end

    // Priority pick: the lowest index wins among equal addresses.
    always_comb begin
        hit = |eq;
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (eq[i]) begin
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/mphy_xfer_ctrl.sv
// Unit sequencer: idle, armed (a channel is selected), moving (words flow).
// Counts the words of a cell or chunk and ends early on an end-of-packet word.
// Assumes unit_len >= 1 and stays constant while a unit is moving.
module mphy_xfer_ctrl
    import mphy_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_req,
    input  logic          enb_low,
    input  logic          src_ready,
    input  logic          word_eop,
    input  logic [CW-1:0] unit_len,
    output logic          sel_take,
    output logic          start,
    output logic          step,
    output logic          unit_end
);

    port_state_t   state;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_eff;

    // Decode this cycle's transfer actions from the state and the bus.
    always_comb begin
        sel_take = sel_req && (state != PS_MOVE);
        start    = (state == PS_ARMED) && enb_low && src_ready;
        step     = start || (state == PS_MOVE);
        cnt_eff  = start ? '0 : cnt;
        unit_end = step && ((cnt_eff == unit_len - CW'(1)) || word_eop);
    end

    // State and word counter updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PS_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                PS_IDLE: begin
                    if (sel_take) begin
                        state <= PS_ARMED;
                    end
                end
                PS_ARMED: begin
                    if (start) begin
                        state <= unit_end ? PS_IDLE : PS_MOVE;
                        cnt   <= cnt_eff + CW'(1);
                    end
                end
                PS_MOVE: begin
                    if (unit_end) begin
                        state <= PS_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: state <= PS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mphy_chunk_port.sv
// PHY-side multi-PHY port: answers polls, latches the selected channel,
// and moves one cell (ATM) or one chunk (packet mode) per selection.
// Assumes each channel can supply a whole unit back to back once ready,
// and that the configuration changes only while no unit is moving.
module mphy_chunk_port
    import mphy_pkg::*;
#(
    parameter int NCH              = 4,
    parameter int AW               = 5,
    parameter int DW               = 16,
    parameter int CELL_WORDS       = 27,
    parameter int CHUNK_STEP_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_ppp_mode,
    input  logic [1:0]        cfg_chunk_code,
    input  logic [NCH*AW-1:0] cfg_ch_addr,
    input  logic [AW-1:0]     rx_addr,
    input  logic              rx_enb_n,
    output logic              rx_clav,
    output logic              rx_clav_oe,
    output logic [DW-1:0]     rx_data,
    output logic              rx_val,
    output logic              rx_soc,
    output logic              rx_sop,
    output logic              rx_eop,
    output logic              rx_mod,
    output logic              rx_abort,
    output logic              rx_fcserr,
    input  logic [NCH-1:0]    ch_ready,
    input  logic [NCH*DW-1:0] ch_word,
    input  logic [NCH-1:0]    ch_sop,
    input  logic [NCH-1:0]    ch_eop,
    input  logic [NCH-1:0]    ch_mod,
    input  logic [NCH-1:0]    ch_abort,
    input  logic [NCH-1:0]    ch_fcserr,
    output logic [NCH-1:0]    ch_pop
);

    localparam int IW          = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int BUS_BYTES   = DW / 8;
    localparam int CHUNK_MAX_W = 4 * CHUNK_STEP_BYTES / BUS_BYTES;
    localparam int MAX_W       = (CELL_WORDS > CHUNK_MAX_W) ? CELL_WORDS : CHUNK_MAX_W;
    localparam int CW          = $clog2(MAX_W + 1);

    logic          hit;
    logic [IW-1:0] hit_idx;
    logic [IW-1:0] sel_idx;
    logic          sel_take, start, step, unit_end;
    logic [CW-1:0] unit_len;
    logic [DW-1:0] h_word;
    logic          h_ready, h_sop, h_eop, h_mod, h_abort, h_fcs;
    logic          pkt_eop;

    mphy_addr_match #(.NCH(NCH), .AW(AW), .IW(IW)) u_match (
        .addr     (rx_addr),
        .cfg_addr (cfg_ch_addr),
        .hit      (hit),
        .idx      (hit_idx)
    );

    // Head word and flags of the currently selected channel.
    always_comb begin
        h_word  = '0;
        h_ready = 1'b0;
        h_sop   = 1'b0;
        h_eop   = 1'b0;
        h_mod   = 1'b0;
        h_abort = 1'b0;
        h_fcs   = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (sel_idx == IW'(i)) begin
                h_word  = ch_word[i*DW +: DW];
                h_ready = ch_ready[i];
                h_sop   = ch_sop[i];
                h_eop   = ch_eop[i];
                h_mod   = ch_mod[i];
                h_abort = ch_abort[i];
                h_fcs   = ch_fcserr[i];
            end
        end
    end

    // Unit length and early end apply only in packet mode.
    always_comb begin
        pkt_eop  = cfg_ppp_mode && h_eop;
        unit_len = cfg_ppp_mode
                 ? CW'(chunk_words(cfg_chunk_code, CHUNK_STEP_BYTES, BUS_BYTES))
                 : CW'(CELL_WORDS);
    end

    mphy_xfer_ctrl #(.CW(CW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_req   (rx_enb_n && hit),
        .enb_low   (!rx_enb_n),
        .src_ready (h_ready),
        .word_eop  (pkt_eop),
        .unit_len  (unit_len),
        .sel_take  (sel_take),
        .start     (start),
        .step      (step),
        .unit_end  (unit_end)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_pop
        assign ch_pop[g] = step && (sel_idx == IW'(g));
    end

    // Latch the channel chosen by a selection cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_idx <= '0;
        end else if (sel_take) begin
            sel_idx <= hit_idx;
        end
    end

    // Poll response for the address seen this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_clav    <= 1'b0;
            rx_clav_oe <= 1'b0;
        end else begin
            rx_clav    <= hit && ch_ready[hit_idx];
            rx_clav_oe <= hit;
        end
    end

    // Register the moved word and its sideband flags onto the bus.
    always_ff @(posedge clk) begin
        if (!rst_n || !step) begin
            rx_data   <= '0;
            rx_val    <= 1'b0;
            rx_soc    <= 1'b0;
            rx_sop    <= 1'b0;
            rx_eop    <= 1'b0;
            rx_mod    <= 1'b0;
            rx_abort  <= 1'b0;
            rx_fcserr <= 1'b0;
        end else begin
            rx_data   <= h_word;
            rx_val    <= 1'b1;
            rx_soc    <= start;
            rx_sop    <= cfg_ppp_mode && h_sop;
            rx_eop    <= pkt_eop;
            rx_mod    <= pkt_eop && h_mod;
            rx_abort  <= pkt_eop && h_abort;
            rx_fcserr <= pkt_eop && h_fcs;
        end
    end

endmodule

// File: rtl/mphy_chunk_port_chk.sv
// Property checker for mphy_chunk_port, attached by bind below.
// Tracks the length of each run of bus words with a local counter.
module mphy_chunk_port_chk #(
    parameter int NCH              = 4,
    parameter int DW               = 16,
    parameter int CELL_WORDS       = 27,
    parameter int CHUNK_STEP_BYTES = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cfg_ppp_mode,
    input logic           rx_clav,
    input logic           rx_clav_oe,
    input logic           rx_val,
    input logic           rx_soc,
    input logic           rx_sop,
    input logic           rx_eop,
    input logic           rx_mod,
    input logic           rx_abort,
    input logic           rx_fcserr,
    input logic [NCH-1:0] ch_pop
);

    localparam int CHUNK_MAX_W = 4 * CHUNK_STEP_BYTES / (DW / 8);

    int run_q;
    int run_now;

    // Length of the current run of words, counting the word on the bus.
    always_comb begin
        run_now = rx_val ? (rx_soc ? 1 : run_q + 1) : 0;
    end

    // Keep the run length for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 0;
        end else begin
            run_q <= run_now;
        end
    end

    p_reset_quiet_r10: assert property (@(posedge clk)
        !rst_n |=> (!rx_val && !rx_clav && !rx_clav_oe && !rx_soc));

    p_clav_gated_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clav |-> rx_clav_oe);

    p_pop_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_pop));

    p_pop_to_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_pop) |=> rx_val);

    p_no_pop_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(|ch_pop) |=> !rx_val);

    p_first_soc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_val) |-> rx_soc);

    p_atm_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_ppp_mode && rx_val) |-> !(rx_sop || rx_eop || rx_mod || rx_abort || rx_fcserr));

    p_atm_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rx_val) && !cfg_ppp_mode) |-> (run_q == CELL_WORDS));

    p_side_on_eop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_abort || rx_fcserr || rx_mod) |-> rx_eop);

    p_run_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_val |-> (run_now <= (cfg_ppp_mode ? CHUNK_MAX_W : CELL_WORDS)));

endmodule

bind mphy_chunk_port mphy_chunk_port_chk #(
    .NCH              (NCH),
    .DW               (DW),
    .CELL_WORDS       (CELL_WORDS),
    .CHUNK_STEP_BYTES (CHUNK_STEP_BYTES)
) u_chk (.*);

// File: tb/mphy_chunk_port_bench.sv
`timescale 1ns/1ps
// Bench: behavioural cycle model of the port, compared on every clock.
module mphy_chunk_port_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_ppp_mode;
    logic [1:0]  cfg_chunk_code;
    logic [19:0] cfg_ch_addr;
    logic [4:0]  rx_addr;
    logic        rx_enb_n;
    logic        rx_clav, rx_clav_oe, rx_val, rx_soc, rx_sop, rx_eop, rx_mod, rx_abort, rx_fcserr;
    logic [15:0] rx_data;
    logic [3:0]  ch_ready, ch_sop, ch_eop, ch_mod, ch_abort, ch_fcserr, ch_pop;
    logic [63:0] ch_word;

    always #10 clk = ~clk;

    mphy_chunk_port u_mphy_chunk_port (.*);

    // Source entries: [15:0] data, 16 sop, 17 eop, 18 mod, 19 abort, 20 fcs.
    logic [20:0] srcq [4][$];
    int          cfg_a [4] = '{5, 9, 9, 30};

    int   nchk = 0, nfail = 0, cyc = 0, obs_words = 0;
    bit   done = 0;
    int   m_state = 0, m_sel = 0, m_cnt = 0;
    int   m_hit, m_hi, m_unit, m_cnt_e;
    bit   m_start, m_step, m_end, m_eop;
    logic [20:0] m_h;
    logic [15:0] e_data;
    bit   e_val, e_soc, e_sop, e_eop, e_mod, e_ab, e_fcs, e_clav, e_oe;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [20:0] head(int c);
        if (srcq[c].size() > 0) return srcq[c][0];
        return '0;
    endfunction

    task automatic apply();
        for (int c = 0; c < 4; c++) begin
            logic [20:0] h;
            h = head(c);
            ch_word[c*16 +: 16] = h[15:0];
            ch_sop[c]    = h[16];
            ch_eop[c]    = h[17];
            ch_mod[c]    = h[18];
            ch_abort[c]  = h[19];
            ch_fcserr[c] = h[20];
        end
    endtask

    // One clock: drive, check pops, advance the model, check the bus.
    task automatic cycle();
        apply();
        #1;
        m_hit = 0; m_hi = 0;
        for (int i = 3; i >= 0; i--) begin
            if (int'(rx_addr) == cfg_a[i]) begin m_hit = 1; m_hi = i; end
        end
        m_unit  = cfg_ppp_mode ? (int'(cfg_chunk_code) + 1) * 8 : 27;
        m_start = (m_state == 1) && !rx_enb_n && ch_ready[m_sel];
        m_step  = m_start || (m_state == 2);
        m_cnt_e = m_start ? 0 : m_cnt;
        m_h     = head(m_sel);
        m_eop   = cfg_ppp_mode && m_h[17];
        m_end   = m_step && ((m_cnt_e == m_unit - 1) || m_eop);
        if (rst_n) chk("R9", "ch_pop", 32'(ch_pop), m_step ? (32'd1 << m_sel) : 32'd0);
        @(posedge clk);
        #1;
        if (!rst_n) begin
            m_state = 0; m_sel = 0; m_cnt = 0;
            {e_val, e_soc, e_sop, e_eop, e_mod, e_ab, e_fcs, e_clav, e_oe} = '0;
            e_data = '0;
        end else begin
            e_oe   = (m_hit != 0);
            e_clav = (m_hit != 0) && ch_ready[m_hi];
            e_val  = m_step;
            e_data = m_step ? m_h[15:0] : 16'h0;
            e_soc  = m_step && (m_cnt_e == 0);
            e_sop  = m_step && cfg_ppp_mode && m_h[16];
            e_eop  = m_step && m_eop;
            e_mod  = m_step && m_eop && m_h[18];
            e_ab   = m_step && m_eop && m_h[19];
            e_fcs  = m_step && m_eop && m_h[20];
            if (m_step) void'(srcq[m_sel].pop_front());
            if (m_state != 2 && rx_enb_n && m_hit != 0) begin
                m_sel = m_hi; m_state = 1;
            end else if (m_start) begin
                m_state = m_end ? 0 : 2; m_cnt = 1;
            end else if (m_state == 2) begin
                if (m_end) begin m_state = 0; m_cnt = 0; end
                else m_cnt = m_cnt + 1;
            end
        end
        @(negedge clk);
        chk("R1", "rx_clav_oe", 32'(rx_clav_oe), 32'(e_oe));
        chk("R1", "rx_clav", 32'(rx_clav), 32'(e_clav));
        chk("R3", "rx_val", 32'(rx_val), 32'(e_val));
        chk("R3", "rx_soc", 32'(rx_soc), 32'(e_soc));
        chk("R9", "rx_data", 32'(rx_data), 32'(e_data));
        chk("R6", "rx_sop", 32'(rx_sop), 32'(e_sop));
        chk("R6", "rx_eop", 32'(rx_eop), 32'(e_eop));
        chk("R6", "rx_mod", 32'(rx_mod), 32'(e_mod));
        chk("R7", "rx_abort", 32'(rx_abort), 32'(e_ab));
        chk("R7", "rx_fcserr", 32'(rx_fcserr), 32'(e_fcs));
        if (rx_val === 1'b1) obs_words++;
    endtask

    task automatic run(int n);
        for (int k = 0; k < n; k++) cycle();
    endtask

    task automatic expect_words(string tag, int n);
        chk(tag, "words moved", 32'(obs_words), 32'(n));
        obs_words = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            nchk++; nfail++;
            $display("FAIL R3 watchdog actual=%0d expected<=100000", cyc);
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; cfg_ppp_mode = 1'b0; cfg_chunk_code = 2'd0;
        for (int i = 0; i < 4; i++) cfg_ch_addr[i*5 +: 5] = 5'(cfg_a[i]);
        rx_addr = 5'd0; rx_enb_n = 1'b1; ch_ready = 4'b0000;
        run(3);
        // R10: outputs quiet under reset.
        chk("R10", "rx_val in reset", 32'(rx_val), 0);
        chk("R10", "rx_clav_oe in reset", 32'(rx_clav_oe), 0);
        rst_n = 1'b1;
        obs_words = 0;

        // R1/R2 polling; channel 1 not ready, channel 2 (same address) ready.
        ch_ready = 4'b1101;
        rx_addr = 5'd5; cycle();
        chk("R1", "clav for ready channel", 32'(rx_clav), 1);
        rx_addr = 5'd9; cycle();
        chk("R2", "duplicate address answers lowest channel", 32'({rx_clav_oe, rx_clav}), 32'b10);
        rx_addr = 5'd30; cycle();
        rx_addr = 5'd7; cycle();
        chk("R1", "no match masks clav", 32'({rx_clav_oe, rx_clav}), 0);

        // R4/R3: ATM cell on channel 0, with stray flags on word 3.
        for (int i = 0; i < 27; i++)
            srcq[0].push_back({(i == 3) ? 5'b11111 : 5'b00000, 16'(16'h1000 + i)});
        for (int i = 0; i < 40; i++) srcq[3].push_back({5'b0, 16'(16'h3000 + i)});
        rx_addr = 5'd5; rx_enb_n = 1'b1; cycle();
        rx_enb_n = 1'b0; cycle();
        rx_enb_n = 1'b1; rx_addr = 5'd30; run(10);   // selection during a unit: ignored (R3)
        rx_enb_n = 1'b0; run(20);
        expect_words("R4", 27);
        // R8: no reselect, nothing more moves.
        run(5);
        expect_words("R8", 0);

        // R3: armed channel waits for ready.
        ch_ready[0] = 1'b0;
        for (int i = 0; i < 27; i++) srcq[0].push_back({5'b0, 16'(16'h2000 + i)});
        rx_addr = 5'd5; rx_enb_n = 1'b1; cycle();
        rx_enb_n = 1'b0; run(4);
        expect_words("R3", 0);
        ch_ready[0] = 1'b1; run(30);
        expect_words("R4", 27);

        // R5: all four chunk sizes on channel 3.
        cfg_ppp_mode = 1'b1;
        srcq[3].delete();
        for (int code = 0; code < 4; code++) begin
            cfg_chunk_code = 2'(code);
            for (int i = 0; i < (code + 1) * 8; i++)
                srcq[3].push_back({4'b0000, (code == 0 && i == 0), 16'(16'h4000 + code * 64 + i)});
            rx_addr = 5'd30; rx_enb_n = 1'b1; cycle();
            rx_enb_n = 1'b0; run(36);
            expect_words("R5", (code + 1) * 8);
        end

        // R6/R7: short packet with abort, then one with FCS error, channel 1.
        cfg_chunk_code = 2'd1;
        ch_ready = 4'b1111;
        for (int i = 0; i < 6; i++) srcq[2].push_back({5'b0, 16'(16'hEE00 + i)});
        srcq[1].push_back({5'b00001, 16'hA000});
        srcq[1].push_back({5'b11000, 16'hA001});           // abort/fcs without end: masked
        srcq[1].push_back({5'b00000, 16'hA002});
        srcq[1].push_back({5'b00000, 16'hA003});
        srcq[1].push_back({5'b01110, 16'hA400});           // end, one byte, abort
        rx_addr = 5'd9; rx_enb_n = 1'b1; cycle();
        rx_enb_n = 1'b0; run(20);
        expect_words("R6", 5);
        srcq[1].push_back({5'b00001, 16'hB000});
        srcq[1].push_back({5'b00000, 16'hB001});
        srcq[1].push_back({5'b10010, 16'hB002});           // end with FCS error
        rx_addr = 5'd9; rx_enb_n = 1'b1; cycle();
        rx_enb_n = 1'b0; run(20);
        expect_words("R7", 3);
        chk("R2", "duplicate channel untouched", 32'(srcq[2].size()), 6);

        finish_run();
    end

endmodule